// File: doc/BRIEF.md
# SD Host Command Engine

This block sends a single SD/MMC command over the bidirectional command wire and collects the card's reply. Software programs a 32-bit argument and a control word through a small word-addressed register port. A control write with the start bit set launches the command. The engine then shifts out a 48-bit frame, one bit per SD clock period, with a CRC7 computed over the first 40 bits. If the control word asks for a reply, the engine releases the wire and waits for a start bit from the card. It then captures either a 48-bit or a 136-bit reply, places it in four 32-bit response words and raises completion flags in a status register whose flags are cleared by writing ones.

The command wire is open-drain. The engine drives `cmd_o` only while `cmd_oe` is high, and it reads the resolved wire level on `cmd_i`. The SD clock is a free-running division of the system clock. The host changes the wire on the falling SD clock edge and samples it on the rising edge.

Register map (word index on `reg_addr`): 0 argument, 1 control, 2 status, 3..6 response words 0..3.

Top module: `sdcmd_host`

## Requirements
- R1: After reset, the status, argument, control and all four response words read 0, `cmd_oe` is low and `cmd_o` is high.
- R2: A started command sends 48 bits MSB first while `cmd_oe` is high, one bit per `sd_clk` period, changed on the falling edge. The bits are: a 0, then control bit 6, then control bits 5:0, then the 32-bit argument, then a CRC7 (polynomial x^7+x^3+1, zero start value) over those 40 bits, then a 1.
- R3: With control bit 9 clear, status bit 11 is set and busy (status bit 8) drops at the end of the stop bit. Status bits 9, 10 and 12 stay clear.
- R4: With control bit 9 set and bit 10 clear, a 48-bit reply sets status bits 11 and 9. Response word 0 holds reply bits 39:8 (the 32 bits after the start, direction and index fields). Words 1 to 3 read 0.
- R5: With control bits 9 and 10 set, a 136-bit reply sets status bits 11 and 9. Response words 0..3 hold the last 128 reply bits, with word 0 the most significant. No CRC check is made.
- R6: For a short reply, status bit 12 is set together with bit 9 when reply bits 7:1 differ from the CRC7 of reply bits 47:8. The check is skipped when the command index is 1 or 41.
- R7: After the wire is released, 64 sampled high levels without a start bit set status bit 10 and end the command, with bit 9 clear. A start bit found on the 64th sample is still accepted.
- R8: Writing the status word clears each flag whose written bit is 1 and leaves the others alone. Writing all ones clears every flag.
- R9: Status bit 8 reads 1 for the whole command. While it is set, control writes are ignored: the control word keeps its value and no further frame is sent.
- R10: `sd_clk` has a period of CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| sd_clk | output | 1 | SD clock to the card |
| cmd_o | output | 1 | Command wire value driven by the host |
| cmd_oe | output | 1 | Host drives the command wire when high |
| cmd_i | input | 1 | Resolved command wire level |

## Verification
The frame serializer is swept across all 64 command indices, each with its own argument, so that every index field value and a wide spread of argument and CRC bits are compared against a CRC computed in the bench. Replies from a card model come in three kinds: clean short, corrupted short and long. These tell apart CRC checking, the index-based CRC skip and the word placement of long captures. A reply delayed by 63 periods is set against one delayed by 64 periods to pin the timeout boundary. A second start issued while busy shows whether the busy guard works.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_TX,
    ST_WAIT,
    ST_RX
  } seq_st_e;

  localparam logic [2:0] A_ARG  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_RSP0 = 3'd3;

  localparam int B_HOST  = 6;
  localparam int B_START = 8;
  localparam int B_WANT  = 9;
  localparam int B_LONG  = 10;

  localparam int F_BUSY = 8;
  localparam int F_FIN  = 9;
  localparam int F_TMO  = 10;
  localparam int F_SENT = 11;
  localparam int F_CRC  = 12;

  localparam int CTRL_W = 11;

  function automatic logic [6:0] crc7_of40(input logic [39:0] d);
    logic [6:0] c;
    logic       fb;
    c = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:3], c[2] ^ fb, c[1:0], fb};
    end
    return c;
  endfunction

endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic sd_clk,
  output logic rise_en,
  output logic fall_en
);
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;

  always_comb begin
    fall_en = (cnt_q == CW'(CLK_DIV - 1));
    rise_en = (cnt_q == CW'(HALF - 1));
    cnt_d   = fall_en ? '0 : cnt_q + 1'b1;
    sclk_d  = (cnt_d >= CW'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sd_clk = sclk_q;

  // R10
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_en, fall_en}));

  // R10
  rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_en |=> sd_clk);

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int RSP_TIMEOUT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_en,
  input  logic         fall_en,
  input  logic         start,
  input  logic [5:0]   start_idx,
  input  logic         start_host,
  input  logic         start_want,
  input  logic         start_long,
  input  logic [31:0]  start_arg,
  input  logic         cmd_i,
  output logic         cmd_o,
  output logic         cmd_oe,
  output logic         busy,
  output logic         evt_sent,
  output logic         evt_done,
  output logic         evt_tmo,
  output logic         evt_crc,
  output logic         long_rsp,
  output logic [135:0] rx_frame
);
  localparam int TW = $clog2(RSP_TIMEOUT + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(RSP_TIMEOUT - 1);

  seq_st_e        st_q, st_d;
  logic [47:0]    tx_q, tx_d;
  logic [7:0]     n_q, n_d;
  logic [TW-1:0]  t_q, t_d;
  logic [135:0]   rx_q, rx_d;
  logic           want_q, want_d, long_q, long_d, chk_q, chk_d;
  logic           o_q, o_d, oe_q, oe_d;
  logic [39:0]    head;
  logic [135:0]   rx_shift;
  logic [7:0]     rx_last;

  always_comb begin
    head     = {1'b0, start_host, start_idx, start_arg};
    rx_shift = {rx_q[134:0], cmd_i};
    rx_last  = long_q ? 8'd135 : 8'd47;
    st_d     = st_q;
    tx_d     = tx_q;
    n_d      = n_q;
    t_d      = t_q;
    rx_d     = rx_q;
    want_d   = want_q;
    long_d   = long_q;
    chk_d    = chk_q;
    o_d      = o_q;
    oe_d     = oe_q;
    evt_sent = 1'b0;
    evt_done = 1'b0;
    evt_tmo  = 1'b0;
    evt_crc  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          tx_d   = {head, crc7_of40(head), 1'b1};
          want_d = start_want;
          long_d = start_want & start_long;
          chk_d  = !((start_idx == 6'd1) || (start_idx == 6'd41));
          st_d   = ST_ARM;
        end
      end
      ST_ARM: begin
        if (fall_en) begin
          oe_d = 1'b1;
          o_d  = tx_q[47];
          tx_d = {tx_q[46:0], 1'b1};
          n_d  = 8'd1;
          st_d = ST_TX;
        end
      end
      ST_TX: begin
        if (fall_en) begin
          if (n_q == 8'd48) begin
            oe_d     = 1'b0;
            o_d      = 1'b1;
            evt_sent = 1'b1;
            t_d      = '0;
            st_d     = want_q ? ST_WAIT : ST_IDLE;
          end else begin
            o_d  = tx_q[47];
            tx_d = {tx_q[46:0], 1'b1};
            n_d  = n_q + 8'd1;
          end
        end
      end
      ST_WAIT: begin
        if (rise_en) begin
          if (!cmd_i) begin
            rx_d = rx_shift;
            n_d  = 8'd1;
            st_d = ST_RX;
          end else if (t_q == TMO_LAST) begin
            evt_tmo = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            t_d = t_q + 1'b1;
          end
        end
      end
      ST_RX: begin
        if (rise_en) begin
          rx_d = rx_shift;
          n_d  = n_q + 8'd1;
          if (n_q == rx_last) begin
            evt_done = 1'b1;
            evt_crc  = chk_q && !long_q &&
                       (crc7_of40(rx_shift[47:8]) != rx_shift[7:1]);
            st_d     = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tx_q   <= '0;
      n_q    <= '0;
      t_q    <= '0;
      rx_q   <= '0;
      want_q <= 1'b0;
      long_q <= 1'b0;
      chk_q  <= 1'b0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      tx_q   <= tx_d;
      n_q    <= n_d;
      t_q    <= t_d;
      rx_q   <= rx_d;
      want_q <= want_d;
      long_q <= long_d;
      chk_q  <= chk_d;
      o_q    <= o_d;
      oe_q   <= oe_d;
    end
  end

  assign cmd_o    = o_q;
  assign cmd_oe   = oe_q;
  assign busy     = (st_q != ST_IDLE);
  assign long_rsp = long_q;
  assign rx_frame = rx_shift;

  // R2
  oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  // R2
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_o) |-> $past(fall_en));

  // R7
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_tmo && evt_done));

endmodule

// File: rtl/sdcmd_host.sv
module sdcmd_host
  import sdcmd_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int RSP_TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sd_clk,
  output logic        cmd_o,
  output logic        cmd_oe,
  input  logic        cmd_i
);
  localparam int NRSP = 4;

  logic              rise_en, fall_en, busy;
  logic              evt_sent, evt_done, evt_tmo, evt_crc, long_rsp;
  logic [135:0]      rx_frame;
  logic [31:0]       arg_q, arg_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              sent_q, sent_d, fin_q, fin_d, tmo_q, tmo_d, crc_q, crc_d;
  logic [31:0]       rsp_q [NRSP];
  logic [31:0]       rsp_d [NRSP];
  logic              wr_arg, wr_ctrl, wr_stat, start;

  sdcmd_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sd_clk  (sd_clk),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  sdcmd_seq #(.RSP_TIMEOUT(RSP_TIMEOUT)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .start      (start),
    .start_idx  (reg_wdata[5:0]),
    .start_host (reg_wdata[B_HOST]),
    .start_want (reg_wdata[B_WANT]),
    .start_long (reg_wdata[B_LONG]),
    .start_arg  (arg_q),
    .cmd_i      (cmd_i),
    .cmd_o      (cmd_o),
    .cmd_oe     (cmd_oe),
    .busy       (busy),
    .evt_sent   (evt_sent),
    .evt_done   (evt_done),
    .evt_tmo    (evt_tmo),
    .evt_crc    (evt_crc),
    .long_rsp   (long_rsp),
    .rx_frame   (rx_frame)
  );

  always_comb begin
    wr_arg  = reg_we && (reg_addr == A_ARG);
    wr_ctrl = reg_we && (reg_addr == A_CTRL) && !busy;
    wr_stat = reg_we && (reg_addr == A_STAT);
    start   = wr_ctrl && reg_wdata[B_START];

    arg_d  = wr_arg ? reg_wdata : arg_q;
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d          = reg_wdata[CTRL_W-1:0];
      ctrl_d[B_START] = 1'b0;
    end

    sent_d = evt_sent ? 1'b1 : ((wr_stat && reg_wdata[F_SENT]) ? 1'b0 : sent_q);
    fin_d  = evt_done ? 1'b1 : ((wr_stat && reg_wdata[F_FIN])  ? 1'b0 : fin_q);
    tmo_d  = evt_tmo  ? 1'b1 : ((wr_stat && reg_wdata[F_TMO])  ? 1'b0 : tmo_q);
    crc_d  = evt_crc  ? 1'b1 : ((wr_stat && reg_wdata[F_CRC])  ? 1'b0 : crc_q);
  end

  for (genvar w = 0; w < NRSP; w++) begin : g_rsp
    always_comb begin
      if (long_rsp) rsp_d[w] = rx_frame[127 - 32*w -: 32];
      else if (w == 0) rsp_d[w] = rx_frame[39:8];
      else rsp_d[w] = '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_q[w] <= '0;
      else if (evt_done) rsp_q[w] <= rsp_d[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_q  <= '0;
      ctrl_q <= '0;
      sent_q <= 1'b0;
      fin_q  <= 1'b0;
      tmo_q  <= 1'b0;
      crc_q  <= 1'b0;
    end else begin
      arg_q  <= arg_d;
      ctrl_q <= ctrl_d;
      sent_q <= sent_d;
      fin_q  <= fin_d;
      tmo_q  <= tmo_d;
      crc_q  <= crc_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_ARG:  reg_rdata = arg_q;
      A_CTRL: reg_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      A_STAT: begin
        reg_rdata[F_BUSY] = busy;
        reg_rdata[F_FIN]  = fin_q;
        reg_rdata[F_TMO]  = tmo_q;
        reg_rdata[F_SENT] = sent_q;
        reg_rdata[F_CRC]  = crc_q;
      end
      3'd3, 3'd4, 3'd5, 3'd6: reg_rdata = rsp_q[reg_addr - A_RSP0];
      default: reg_rdata = '0;
    endcase
  end

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == A_CTRL) && busy) |=> $stable(ctrl_q));

  // R3
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sent_q && (fin_q || tmo_q || !cmd_oe)));

  // R6
  crc_with_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_crc |=> (fin_q && crc_q));

endmodule

// File: tb/sdcmd_host_tb.sv
`timescale 1ns/1ps
module sdcmd_host_tb_top;
  localparam int CLK_DIV = 4;
  localparam int S_BUSY = 1 << 8;
  localparam int S_FIN  = 1 << 9;
  localparam int S_TMO  = 1 << 10;
  localparam int S_SENT = 1 << 11;
  localparam int S_CRC  = 1 << 12;

  logic        clk, rst_n, reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sd_clk, cmd_o, cmd_oe, cmd_i;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // card model state
  logic         card_line = 1'b1;
  logic [47:0]  cap_bits  = '0;
  int           cap_cnt   = 0;
  int           frame_cnt = 0;
  bit           c_go      = 0;
  int           c_k = 0, c_idx = 0;
  int           c_mode = 0, c_delay = 4, c_len = 48;
  logic [135:0] c_bits = '0;

  sdcmd_host #(.CLK_DIV(CLK_DIV), .RSP_TIMEOUT(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_clk(sd_clk),
    .cmd_o(cmd_o), .cmd_oe(cmd_oe), .cmd_i(cmd_i)
  );

  assign cmd_i = (cmd_oe ? cmd_o : 1'b1) & card_line;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge sd_clk) begin
    if (cmd_oe) begin
      cap_bits <= {cap_bits[46:0], cmd_o};
      cap_cnt  <= cap_cnt + 1;
      if (cap_cnt == 47) begin
        frame_cnt <= frame_cnt + 1;
        c_go  <= (c_mode != 0);
        c_k   <= 0;
        c_idx <= 0;
      end
    end else begin
      cap_cnt <= 0;
    end
  end

  always @(negedge sd_clk) begin
    if (c_go) begin
      if (c_k >= c_delay) begin
        if (c_idx == c_len) begin
          card_line <= 1'b1;
          c_go      <= 0;
        end else begin
          card_line <= c_bits[c_len - 1 - c_idx];
          c_idx     <= c_idx + 1;
        end
      end
      c_k <= c_k + 1;
    end
  end

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [6:0] r = 7'd0;
    for (int i = 0; i < 40; i++) begin
      logic top;
      top = r[6] ^ d[39 - i];
      r = {r[5:0], 1'b0} ^ (top ? 7'b0001001 : 7'b0000000);
    end
    return r;
  endfunction

  function automatic logic [47:0] mk48(input logic b0, input logic b1,
                                       input logic [5:0] idx, input logic [31:0] a);
    logic [39:0] h = {b0, b1, idx, a};
    return {h, ref_crc(h), 1'b1};
  endfunction

  task automatic chk(input string tag, input logic [135:0] act, input logic [135:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input logic [5:0] idx, input bit host,
                                            input bit want, input bit lng);
    return (32'(lng) << 10) | (32'(want) << 9) | (32'd1 << 8) |
           (32'(host) << 6) | 32'(idx);
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    int guard = 0;
    do begin
      rd(3'd2, s);
      guard++;
    end while (s[8] && guard < 5000);
  endtask

  task automatic settle();
    int guard = 0;
    while (c_go && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4 * CLK_DIV) @(negedge clk);
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] a, input bit host,
                       input bit want, input bit lng);
    wr(3'd0, a);
    wr(3'd1, ctrl_word(idx, host, want, lng));
    wait_idle();
    settle();
  endtask

  task automatic set_short(input logic [5:0] idx, input logic [31:0] p,
                           input bit corrupt, input int dly);
    logic [47:0] f = mk48(1'b0, 1'b0, idx, p);
    if (corrupt) f[1] = ~f[1];
    c_bits = {88'd0, f}; c_len = 48; c_mode = 1; c_delay = dly;
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, s, w0, w1, w2, w3;
    realtime t0, t1;
    int fc;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg %0d", a), 136'(v), 136'd0);
    end
    chk("R1 cmd_oe", 136'(cmd_oe), 136'd0);
    chk("R1 cmd_o", 136'(cmd_o), 136'd1);

    // R10 sd_clk period
    @(posedge sd_clk); t0 = $realtime;
    @(posedge sd_clk); t1 = $realtime;
    chk("R10 period", 136'(int'(t1 - t0)), 136'(8 * CLK_DIV));

    // R2/R3/R8 sweep of every index, no reply
    c_mode = 0;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a = 32'h9E3779B9 * (i + 1) ^ {i[7:0], 24'h5A0F3C};
      issue(6'(i), a, 1'b1, 1'b0, 1'b0);
      chk($sformatf("R2 frame idx %0d", i), 136'(cap_bits), 136'(mk48(1'b0, 1'b1, 6'(i), a)));
      rd(3'd2, s);
      chk($sformatf("R3 status idx %0d", i), 136'(s), 136'(S_SENT));
      wr(3'd2, 32'hFFFF_FFFF);
      rd(3'd2, s);
      chk("R8 all-ones clear", 136'(s), 136'd0);
    end

    // R2 direction bit cleared
    issue(6'd5, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    chk("R2 frame host=0", 136'(cap_bits), 136'(mk48(1'b0, 1'b0, 6'd5, 32'h1)));
    wr(3'd2, 32'hFFFF_FFFF);

    // R4 short replies
    for (int i = 0; i < 6; i++) begin
      logic [5:0]  ix = 6'(3 + 7 * i);
      logic [31:0] p  = 32'hC3A5_0000 + 32'(i * 32'h1111);
      set_short(ix, p, 1'b0, 2 + i);
      issue(ix, 32'h1000 + 32'(i), 1'b1, 1'b1, 1'b0);
      rd(3'd2, s);
      chk($sformatf("R4 status idx %0d", ix), 136'(s), 136'(S_SENT | S_FIN));
      rd(3'd3, w0); rd(3'd4, w1); rd(3'd5, w2); rd(3'd6, w3);
      chk("R4 word0", 136'(w0), 136'(p));
      chk("R4 words1-3 zero", 136'({w1, w2, w3}), 136'd0);
      wr(3'd2, 32'hFFFF_FFFF);
    end

    // R6 corrupted CRC on a checked index
    set_short(6'd17, 32'h0BAD_F00D, 1'b1, 3);
    issue(6'd17, 32'h200, 1'b1, 1'b1, 1'b0);
    rd(3'd2, s);
    chk("R6 crc flagged", 136'(s), 136'(S_SENT | S_FIN | S_CRC));

    // R8 partial clears
    wr(3'd2, S_FIN);
    rd(3'd2, s);
    chk("R8 partial clear", 136'(s), 136'(S_SENT | S_CRC));
    wr(3'd2, 32'd0);
    rd(3'd2, s);
    chk("R8 zero write no effect", 136'(s), 136'(S_SENT | S_CRC));
    wr(3'd2, 32'hFFFF_FFFF);

    // R6 skipped indices
    set_short(6'd41, 32'hFF80_8000, 1'b1, 3);
    issue(6'd41, 32'h0030_0000, 1'b1, 1'b1, 1'b0);
    rd(3'd2, s);
    chk("R6 skip idx 41", 136'(s), 136'(S_SENT | S_FIN));
    wr(3'd2, 32'hFFFF_FFFF);
    set_short(6'd1, 32'h80FF_C000, 1'b1, 3);
    issue(6'd1, 32'h00FF_C000, 1'b1, 1'b1, 1'b0);
    rd(3'd2, s);
    chk("R6 skip idx 1", 136'(s), 136'(S_SENT | S_FIN));
    wr(3'd2, 32'hFFFF_FFFF);

    // R5 long reply
    c_bits = {2'b00, 6'h3F, 32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C};
    c_len = 136; c_mode = 2; c_delay = 5;
    issue(6'd2, 32'h0, 1'b1, 1'b1, 1'b1);
    rd(3'd2, s);
    chk("R5 status", 136'(s), 136'(S_SENT | S_FIN));
    rd(3'd3, w0); rd(3'd4, w1); rd(3'd5, w2); rd(3'd6, w3);
    chk("R5 words", 136'({w0, w1, w2, w3}),
        136'({32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C}));
    wr(3'd2, 32'hFFFF_FFFF);

    // R7 boundary: 63 high samples accepted, 64 time out
    set_short(6'd9, 32'h1357_9BDF, 1'b0, 63);
    issue(6'd9, 32'h9, 1'b1, 1'b1, 1'b0);
    rd(3'd2, s);
    chk("R7 delay 63 accepted", 136'(s), 136'(S_SENT | S_FIN));
    wr(3'd2, 32'hFFFF_FFFF);
    set_short(6'd9, 32'h2468_ACE0, 1'b0, 64);
    issue(6'd9, 32'h9, 1'b1, 1'b1, 1'b0);
    rd(3'd2, s);
    chk("R7 delay 64 timeout", 136'(s), 136'(S_SENT | S_TMO));
    wr(3'd2, 32'hFFFF_FFFF);
    c_mode = 0;
    issue(6'd13, 32'h0, 1'b1, 1'b1, 1'b0);
    rd(3'd2, s);
    chk("R7 silent card timeout", 136'(s), 136'(S_SENT | S_TMO));
    wr(3'd2, S_TMO);
    rd(3'd2, s);
    chk("R8 clear timeout only", 136'(s), 136'(S_SENT));
    wr(3'd2, 32'hFFFF_FFFF);

    // R9 busy guard
    set_short(6'd7, 32'hA5A5_5A5A, 1'b0, 40);
    fc = frame_cnt;
    wr(3'd0, 32'h7777_0007);
    wr(3'd1, ctrl_word(6'd7, 1'b1, 1'b1, 1'b0));
    rd(3'd2, s);
    chk("R9 busy set", 136'(s[8]), 136'd1);
    wr(3'd1, ctrl_word(6'd12, 1'b1, 1'b0, 1'b0));
    rd(3'd1, v);
    chk("R9 ctrl held", 136'(v), 136'(ctrl_word(6'd7, 1'b1, 1'b1, 1'b0) & ~32'h100));
    wait_idle();
    settle();
    repeat (100) @(negedge clk);
    chk("R9 one frame only", 136'(frame_cnt - fc), 136'd1);
    chk("R9 first frame sent", 136'(cap_bits), 136'(mk48(1'b0, 1'b1, 6'd7, 32'h7777_0007)));
    rd(3'd3, w0);
    chk("R9 reply of first", 136'(w0), 136'(32'hA5A5_5A5A));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule